// File: doc/BRIEF.md
# Nonvolatile Store/Recall Cycle Controller

This block sequences data transfers between a shadow SRAM array and the nonvolatile copy behind it. A store erases the nonvolatile copy and then programs it from the SRAM. A recall clears the SRAM and then copies the nonvolatile data back. Each step is started with a one-cycle pulse and ends when the array returns a one-cycle done pulse. The whole cycle is also held open for a minimum length set by a parameter, counted in clock cycles.

Stores can be requested in three ways: by the software sequence detector, by another device pulling the shared open-drain busy line low, or by the supply falling through the switch level when the block runs in automatic mode. The busy line is split into an observed level (`busy_line_i`) and a pull-down enable (`busy_pull_o`); the wired-AND sits outside the block. Only software stores are unconditional. Every other store request needs at least one accepted SRAM write since the last completed store or recall.

After a store, and after an ignored line request, the block keeps the SRAM locked out until the line reads high again. A fall below the reset level latches a power-up recall, which runs as soon as the supply is back above the switch level. All inputs are synchronous to `clk`. The mode input is captured once, right after reset.

Top module: `nv_cycle_ctrl`

## Requirements
- R1: From reset the block holds outputs disabled (`out_disable_o`=1, `sram_inhibit_o`=1, `busy_pull_o`=0) and starts no recall while `below_switch_i`=1. In the cycle after the supply reads above the switch level, it pulses `clr_go_o`, then later `copy_go_o`. `out_disable_o` stays 1 for exactly PWR_RCL_CYC cycles counted from the `clr_go_o` cycle.
- R2: A `sw_store_i` pulse in idle starts a store even when nothing was written. `erase_go_o` comes in the next cycle, and `prog_go_o` follows only after `erase_done_i`.
- R3: If the busy line is pulled low externally while the written flag is clear, no store step starts. The SRAM stays disabled until the line reads high, and is released one cycle after that.
- R4: If the busy line falls externally while the written flag is set, writes are blocked in that same cycle. Reads stay enabled (`out_disable_o`=0) for HOLD_CYC cycles, and `erase_go_o` rises HOLD_CYC+1 cycles after the line was first seen low.
- R5: During every store, whatever its origin, `busy_pull_o` is 1 from the first erase cycle until completion, which is STORE_CYC cycles later. It then drops to 0.
- R6: After a store completes, `out_disable_o` stays 1 for as long as the line is held low. It clears one cycle after the line reads high.
- R7: A `sw_recall_i` pulse starts a recall with a clear step and then a copy step. No erase or program pulse occurs and the busy line is never pulled. Outputs stay disabled for SW_RCL_CYC cycles.
- R8: The written flag is set only by a write that is accepted (`wr_req_i`=1 while `sram_inhibit_o`=0). It is cleared when a store or a recall completes.
- R9: While `below_switch_i`=1, `sram_inhibit_o`=1, and a write request made then does not set the written flag.
- R10: In automatic mode (`auto_mode_i`=1 at reset), a rising `below_switch_i` with the flag set pulls the busy line in the next cycle. Once the line reads low, the HOLD_CYC window runs and the store follows. With the flag clear, the block does not pull the line.
- R11: If the line stays high for ABORT_CYC cycles of pulling, the block releases it and abandons the store without starting any step.
- R12: In inhibit mode (`auto_mode_i`=0 at reset), a supply drop triggers no pull and no store.
- R13: `below_reset_i`=1 disables outputs in the next cycle and latches a power-up recall, which starts once `below_switch_i`=0. A dip below the switch level only, with no fall below the reset level, causes no recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode_i | input | 1 | 1 = automatic store on supply drop, 0 = inhibit mode; captured after reset |
| below_switch_i | input | 1 | Supply is below the switch level |
| below_reset_i | input | 1 | Supply is below the reset level |
| busy_line_i | input | 1 | Observed level of the shared open-drain busy line (0 = low) |
| busy_pull_o | output | 1 | Enables the pull-down on the busy line |
| wr_req_i | input | 1 | External SRAM write strobe |
| sw_store_i | input | 1 | One-cycle store request from the sequence detector |
| sw_recall_i | input | 1 | One-cycle recall request from the sequence detector |
| sram_inhibit_o | output | 1 | SRAM writes blocked |
| out_disable_o | output | 1 | All SRAM access disabled, outputs high impedance |
| erase_go_o | output | 1 | Start pulse for the nonvolatile erase step |
| erase_done_i | input | 1 | Erase step finished |
| prog_go_o | output | 1 | Start pulse for the program step |
| prog_done_i | input | 1 | Program step finished |
| clr_go_o | output | 1 | Start pulse for the SRAM clear step |
| clr_done_i | input | 1 | Clear step finished |
| copy_go_o | output | 1 | Start pulse for the nonvolatile-to-SRAM copy step |
| copy_done_i | input | 1 | Copy step finished |

## Verification
Step pulses are registered, so each one appears in the cycle after the request or done pulse that causes it. The gating outputs follow the state combinationally in that same cycle. `sram_inhibit_o` also reacts within the cycle to the line level and to the supply-below-switch input. The bench drives its inputs just after the falling edge and samples at the next falling edge. It counts falling edges from each stimulus to each result and compares the count with the figure derived in the requirements: HOLD_CYC+1 from a line fall to the erase pulse, and STORE_CYC, SW_RCL_CYC, PWR_RCL_CYC or ABORT_CYC for the pulse and disable widths. Its array model answers each start pulse three cycles later, so every step sequence fits inside the parameterised cycle length.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

  typedef enum logic [3:0] {
    ST_RCL_WAIT  = 4'd0,   // power-up recall pending
    ST_IDLE      = 4'd1,
    ST_PULL      = 4'd2,   // trying to drive the busy line low
    ST_HOLDOFF   = 4'd3,   // grace window for SRAM cycles in flight
    ST_LOCKOUT   = 4'd4,   // wait for busy line high
    ST_ERASE     = 4'd5,
    ST_PROG      = 4'd6,
    ST_ST_SETTLE = 4'd7,   // store: wait out the minimum length
    ST_CLEAR     = 4'd8,
    ST_COPY      = 4'd9,
    ST_RC_SETTLE = 4'd10   // recall: wait out the minimum length
  } nvc_state_e;

endpackage

// File: rtl/nvc_rst_sync.sv
module nvc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/nvc_mode_latch.sv
module nvc_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  output logic auto_o
);

  logic loaded_q, loaded_d;
  logic mode_q, mode_d;

  always_comb begin
    loaded_d = 1'b1;
    mode_d   = loaded_q ? mode_q : mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      loaded_q <= loaded_d;
      mode_q   <= mode_d;
    end
  end

  assign auto_o = mode_q;

endmodule

// File: rtl/nvc_cycle_timer.sv
module nvc_cycle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/nvc_written_flag.sv
module nvc_written_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i)      flag_d = 1'b0;
    else if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/nv_cycle_ctrl.sv
module nv_cycle_ctrl #(
  parameter int unsigned STORE_CYC   = 1000000,
  parameter int unsigned SW_RCL_CYC  = 2000,
  parameter int unsigned PWR_RCL_CYC = 55000,
  parameter int unsigned HOLD_CYC    = 100,
  parameter int unsigned ABORT_CYC   = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_mode_i,
  input  logic below_switch_i,
  input  logic below_reset_i,
  input  logic busy_line_i,
  output logic busy_pull_o,
  input  logic wr_req_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  output logic sram_inhibit_o,
  output logic out_disable_o,
  output logic erase_go_o,
  input  logic erase_done_i,
  output logic prog_go_o,
  input  logic prog_done_i,
  output logic clr_go_o,
  input  logic clr_done_i,
  output logic copy_go_o,
  input  logic copy_done_i
);

  import nvc_pkg::*;

  localparam int unsigned RCL_MAX  = (PWR_RCL_CYC > SW_RCL_CYC) ? PWR_RCL_CYC : SW_RCL_CYC;
  localparam int unsigned LONG_MAX = (STORE_CYC > RCL_MAX) ? STORE_CYC : RCL_MAX;
  localparam int unsigned WIN_MAX  = (ABORT_CYC > HOLD_CYC) ? ABORT_CYC : HOLD_CYC;
  localparam int unsigned CYC_W    = $clog2(LONG_MAX + 1);
  localparam int unsigned WIN_W    = $clog2(WIN_MAX + 1);

  localparam logic [CYC_W-1:0] STORE_V = CYC_W'(STORE_CYC - 1);
  localparam logic [CYC_W-1:0] SWR_V   = CYC_W'(SW_RCL_CYC - 1);
  localparam logic [CYC_W-1:0] PWR_V   = CYC_W'(PWR_RCL_CYC - 1);
  localparam logic [WIN_W-1:0] HOLD_V  = WIN_W'(HOLD_CYC - 1);
  localparam logic [WIN_W-1:0] ABORT_V = WIN_W'(ABORT_CYC - 1);

  logic       rst_sync_n;
  logic       auto_q;
  logic       written;
  nvc_state_e state_q, state_d;
  logic       sw_prev_q, sw_prev_d;
  logic       switch_rise;
  logic       cyc_load, cyc_exp, win_load, win_exp;
  logic [CYC_W-1:0] cyc_val;
  logic [WIN_W-1:0] win_val;
  logic       wr_accept, nv_done;
  logic [3:0] go_q, go_d;   // {copy, clr, prog, erase}

  nvc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nvc_mode_latch u_mode (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .mode_i (auto_mode_i),
    .auto_o (auto_q)
  );

  nvc_cycle_timer #(.W(CYC_W)) u_cyc_tmr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (cyc_load),
    .load_val_i (cyc_val),
    .expired_o  (cyc_exp)
  );

  nvc_cycle_timer #(.W(WIN_W)) u_win_tmr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (win_load),
    .load_val_i (win_val),
    .expired_o  (win_exp)
  );

  nvc_written_flag u_wflag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (wr_accept),
    .clr_i  (nv_done),
    .flag_o (written)
  );

  // Supply edge detection: only a fresh fall through the switch level triggers.
  assign sw_prev_d   = below_switch_i;
  assign switch_rise = below_switch_i & ~sw_prev_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    if (below_reset_i) begin
      state_d = ST_RCL_WAIT;
    end else begin
      unique case (state_q)
        ST_RCL_WAIT:  if (!below_switch_i) state_d = ST_CLEAR;
        ST_IDLE: begin
          if (!busy_line_i)                        state_d = written ? ST_HOLDOFF : ST_LOCKOUT;
          else if (auto_q && switch_rise && written) state_d = ST_PULL;
          else if (sw_store_i)                     state_d = ST_ERASE;
          else if (sw_recall_i)                    state_d = ST_CLEAR;
        end
        ST_PULL: begin
          if (!busy_line_i)  state_d = ST_HOLDOFF;
          else if (win_exp)  state_d = ST_IDLE;
        end
        ST_HOLDOFF:   if (win_exp)      state_d = ST_ERASE;
        ST_LOCKOUT:   if (busy_line_i)  state_d = ST_IDLE;
        ST_ERASE:     if (erase_done_i) state_d = ST_PROG;
        ST_PROG:      if (prog_done_i)  state_d = ST_ST_SETTLE;
        ST_ST_SETTLE: if (cyc_exp)      state_d = ST_LOCKOUT;
        ST_CLEAR:     if (clr_done_i)   state_d = ST_COPY;
        ST_COPY:      if (copy_done_i)  state_d = ST_RC_SETTLE;
        ST_RC_SETTLE: if (cyc_exp)      state_d = ST_IDLE;
        default:                        state_d = ST_RCL_WAIT;
      endcase
    end
  end

  // Timer loads on entry to the timed states
  always_comb begin
    cyc_load = ((state_d == ST_ERASE) && (state_q != ST_ERASE)) ||
               ((state_d == ST_CLEAR) && (state_q != ST_CLEAR));
    if (state_d == ST_ERASE)          cyc_val = STORE_V;
    else if (state_q == ST_RCL_WAIT)  cyc_val = PWR_V;
    else                              cyc_val = SWR_V;

    win_load = ((state_d == ST_PULL)    && (state_q != ST_PULL)) ||
               ((state_d == ST_HOLDOFF) && (state_q != ST_HOLDOFF));
    win_val  = (state_d == ST_PULL) ? ABORT_V : HOLD_V;
  end

  // Step start pulses, registered so each appears in the first cycle of its step
  always_comb begin
    go_d[0] = (state_d == ST_ERASE) && (state_q != ST_ERASE);
    go_d[1] = (state_d == ST_PROG)  && (state_q != ST_PROG);
    go_d[2] = (state_d == ST_CLEAR) && (state_q != ST_CLEAR);
    go_d[3] = (state_d == ST_COPY)  && (state_q != ST_COPY);
  end

  // Written-flag control
  always_comb begin
    wr_accept = wr_req_i & ~sram_inhibit_o;
    nv_done   = ((state_q == ST_ST_SETTLE) && (state_d == ST_LOCKOUT)) ||
                ((state_q == ST_RC_SETTLE) && (state_d == ST_IDLE));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_RCL_WAIT;
      sw_prev_q <= 1'b0;
      go_q      <= '0;
    end else begin
      state_q   <= state_d;
      sw_prev_q <= sw_prev_d;
      go_q      <= go_d;
    end
  end

  // Outputs
  always_comb begin
    out_disable_o  = !((state_q == ST_IDLE) || (state_q == ST_PULL) || (state_q == ST_HOLDOFF));
    sram_inhibit_o = out_disable_o || below_switch_i || (state_q == ST_HOLDOFF) || !busy_line_i;
    busy_pull_o    = (state_q == ST_PULL) || (state_q == ST_HOLDOFF) || (state_q == ST_ERASE) ||
                     (state_q == ST_PROG) || (state_q == ST_ST_SETTLE);
  end

  assign erase_go_o = go_q[0];
  assign prog_go_o  = go_q[1];
  assign clr_go_o   = go_q[2];
  assign copy_go_o  = go_q[3];

endmodule

// File: rtl/nvc_checker.sv
module nvc_checker (
  input logic clk,
  input logic rst_n,
  input logic below_switch_i,
  input logic below_reset_i,
  input logic busy_pull_o,
  input logic sram_inhibit_o,
  input logic out_disable_o,
  input logic erase_go_o,
  input logic prog_go_o,
  input logic clr_go_o,
  input logic copy_go_o
);

  // R4
  rd_block_implies_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable_o |-> sram_inhibit_o);

  // R9
  low_supply_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below_switch_i |-> sram_inhibit_o);

  // R2
  one_step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_go_o, prog_go_o, clr_go_o, copy_go_o}));

  // R5
  erase_holds_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go_o |-> busy_pull_o);

  // R5
  prog_holds_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go_o |-> busy_pull_o);

  // R7
  recall_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_go_o || copy_go_o) |-> !busy_pull_o);

  // R13
  deep_drop_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below_reset_i |=> out_disable_o);

endmodule

bind nv_cycle_ctrl nvc_checker u_nvc_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .below_switch_i (below_switch_i),
  .below_reset_i  (below_reset_i),
  .busy_pull_o    (busy_pull_o),
  .sram_inhibit_o (sram_inhibit_o),
  .out_disable_o  (out_disable_o),
  .erase_go_o     (erase_go_o),
  .prog_go_o      (prog_go_o),
  .clr_go_o       (clr_go_o),
  .copy_go_o      (copy_go_o)
);

// File: tb/tb_nv_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_nv_cycle_ctrl;

  localparam int STORE = 40;
  localparam int SWR   = 12;
  localparam int PWR   = 20;
  localparam int HOLD  = 5;
  localparam int ABRT  = 8;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_mode = 1'b1;
  logic below_switch = 1'b1;
  logic below_reset = 1'b0;
  logic wr_req = 1'b0;
  logic sw_store = 1'b0;
  logic sw_recall = 1'b0;
  logic ext_pull = 1'b0;
  logic ext_high = 1'b0;
  logic erase_done = 1'b0, prog_done = 1'b0, clr_done = 1'b0, copy_done = 1'b0;
  logic busy_line, busy_pull, sram_inhibit, out_disable;
  logic erase_go, prog_go, clr_go, copy_go;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int erase_n = 0, prog_n = 0, clr_n = 0, copy_n = 0;
  int t_erase = 0, t_prog = 0, t_clr = 0, t_copy = 0;
  int e_cnt = 0, p_cnt = 0, c_cnt = 0, y_cnt = 0;

  assign busy_line = ext_high ? 1'b1 : ~(busy_pull | ext_pull);

  nv_cycle_ctrl #(
    .STORE_CYC(STORE), .SW_RCL_CYC(SWR), .PWR_RCL_CYC(PWR),
    .HOLD_CYC(HOLD), .ABORT_CYC(ABRT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .auto_mode_i(auto_mode),
    .below_switch_i(below_switch), .below_reset_i(below_reset),
    .busy_line_i(busy_line), .busy_pull_o(busy_pull),
    .wr_req_i(wr_req), .sw_store_i(sw_store), .sw_recall_i(sw_recall),
    .sram_inhibit_o(sram_inhibit), .out_disable_o(out_disable),
    .erase_go_o(erase_go), .erase_done_i(erase_done),
    .prog_go_o(prog_go), .prog_done_i(prog_done),
    .clr_go_o(clr_go), .clr_done_i(clr_done),
    .copy_go_o(copy_go), .copy_done_i(copy_done)
  );

  initial forever #2 clk = ~clk;

  // Behavioural array: answers each start pulse LAT cycles later.
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    erase_done = 1'b0; prog_done = 1'b0; clr_done = 1'b0; copy_done = 1'b0;
    if (e_cnt != 0) begin e_cnt--; if (e_cnt == 0) erase_done = 1'b1; end
    if (p_cnt != 0) begin p_cnt--; if (p_cnt == 0) prog_done = 1'b1; end
    if (c_cnt != 0) begin c_cnt--; if (c_cnt == 0) clr_done = 1'b1; end
    if (y_cnt != 0) begin y_cnt--; if (y_cnt == 0) copy_done = 1'b1; end
    if (erase_go) begin e_cnt = LAT; erase_n++; t_erase = cyc; end
    if (prog_go)  begin p_cnt = LAT; prog_n++;  t_prog = cyc;  end
    if (clr_go)   begin c_cnt = LAT; clr_n++;   t_clr = cyc;   end
    if (copy_go)  begin y_cnt = LAT; copy_n++;  t_copy = cyc;  end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy_pull && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic count_disabled(output int n);
    n = 0;
    while (out_disable && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 500; i++) begin
      if (!out_disable) break;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic mode, input logic low_sw);
    @(negedge clk);
    rst_n = 1'b0; auto_mode = mode; below_switch = low_sw; below_reset = 1'b0;
    ext_pull = 1'b0; ext_high = 1'b0; wr_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_write(input string req);
    wr_req = 1'b1;
    #1 chk({req, " write accepted"}, sram_inhibit, 0);
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic line_request_ignored(input string req);
    int e0;
    e0 = erase_n;
    ext_pull = 1'b1;
    repeat (8) @(negedge clk);
    chk({req, " no erase"}, erase_n, e0);
    chk({req, " locked out"}, out_disable, 1);
    chk({req, " no pull"}, busy_pull, 0);
    ext_pull = 1'b0;
    @(negedge clk);
    chk({req, " released"}, out_disable, 0);
  endtask

  task automatic t_powerup();
    int n;
    chk("R1 reset disable", out_disable, 1);
    chk("R1 reset inhibit", sram_inhibit, 1);
    chk("R1 reset no pull", busy_pull, 0);
    chk("R1 no recall while low", clr_n, 0);
    below_switch = 1'b0;
    @(negedge clk);
    chk("R1 clear pulse", clr_go, 1);
    count_disabled(n);
    chk("R1 recall length", n, PWR);
    chk("R1 copy once", copy_n, 1);
    chk("R1 copy after clear", int'(t_copy > t_clr), 1);
    chk("R1 no erase", erase_n, 0);
  endtask

  task automatic t_sw_store();
    int n;
    sw_store = 1'b1;
    @(negedge clk);
    sw_store = 1'b0;
    chk("R2 erase pulse", erase_go, 1);
    count_busy(n);
    chk("R5 pull length", n, STORE);
    chk("R2 program once", prog_n, 1);
    chk("R2 program after erase", int'(t_prog > t_erase + LAT - 1), 1);
    chk("R6 locked after store", out_disable, 1);
    @(negedge clk);
    chk("R6 released", out_disable, 0);
  endtask

  task automatic t_sw_store_hold();
    int n;
    do_write("R8");
    sw_store = 1'b1;
    @(negedge clk);
    sw_store = 1'b0;
    ext_pull = 1'b1;
    count_busy(n);
    chk("R5 pull length held", n, STORE);
    repeat (10) @(negedge clk);
    chk("R6 held low lockout", out_disable, 1);
    ext_pull = 1'b0;
    @(negedge clk);
    chk("R6 exit after line high", out_disable, 0);
  endtask

  task automatic t_hw_store();
    int k, n, rd_ok, wr_blk, pull_ok;
    do_write("R8");
    ext_pull = 1'b1;
    #1 chk("R4 write blocked at fall", sram_inhibit, 1);
    k = 0; rd_ok = 1; wr_blk = 1; pull_ok = 1;
    do begin
      @(negedge clk);
      k++;
      if (!erase_go) begin
        if (out_disable) rd_ok = 0;
        if (!sram_inhibit) wr_blk = 0;
        if (!busy_pull) pull_ok = 0;
      end
    end while (!erase_go && k < 50);
    ext_pull = 1'b0;
    chk("R4 erase delay", k, HOLD + 1);
    chk("R4 reads during window", rd_ok, 1);
    chk("R4 writes blocked in window", wr_blk, 1);
    chk("R5 pull in window", pull_ok, 1);
    count_busy(n);
    chk("R5 hw store length", n, STORE);
    wait_ready();
    line_request_ignored("R8 flag cleared by store");
  endtask

  task automatic t_auto_store();
    int k, c0;
    do_write("R10");
    below_switch = 1'b1;
    @(negedge clk);
    chk("R10 pull on drop", busy_pull, 1);
    k = 1;
    while (!erase_go && k < 50) begin @(negedge clk); k++; end
    chk("R10 erase delay", k, HOLD + 2);
    while (busy_pull) @(negedge clk);
    wait_ready();
    repeat (10) @(negedge clk);
    chk("R10 no second pull", busy_pull, 0);
    c0 = clr_n;
    below_switch = 1'b0;
    repeat (10) @(negedge clk);
    chk("R13 shallow dip no recall", clr_n, c0);
    chk("R13 shallow dip enabled", out_disable, 0);
  endtask

  task automatic t_low_supply_writes();
    below_switch = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 no pull with flag clear", busy_pull, 0);
    wr_req = 1'b1;
    #1 chk("R9 write blocked", sram_inhibit, 1);
    @(negedge clk);
    wr_req = 1'b0;
    below_switch = 1'b0;
    @(negedge clk);
    line_request_ignored("R9 write not counted");
  endtask

  task automatic t_abort();
    int n, e0;
    e0 = erase_n;
    do_write("R11");
    ext_high = 1'b1;
    below_switch = 1'b1;
    @(negedge clk);
    count_busy(n);
    chk("R11 pull window", n, ABRT);
    repeat (5) @(negedge clk);
    chk("R11 no erase", erase_n, e0);
    chk("R11 still enabled", out_disable, 0);
    chk("R11 line released", busy_pull, 0);
    ext_high = 1'b0;
    below_switch = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_sw_recall();
    int n, e0, p0, c0;
    e0 = erase_n; p0 = prog_n; c0 = copy_n;
    sw_recall = 1'b1;
    @(negedge clk);
    sw_recall = 1'b0;
    chk("R7 clear pulse", clr_go, 1);
    chk("R7 no pull", busy_pull, 0);
    count_disabled(n);
    chk("R7 recall length", n, SWR);
    chk("R7 copy once", copy_n, c0 + 1);
    chk("R7 no erase", erase_n, e0);
    chk("R7 no program", prog_n, p0);
    line_request_ignored("R8 flag cleared by recall");
  endtask

  task automatic t_brownout_reset();
    int n, c0;
    c0 = clr_n;
    below_switch = 1'b1;
    below_reset = 1'b1;
    @(negedge clk);
    chk("R13 disabled", out_disable, 1);
    chk("R13 no pull", busy_pull, 0);
    repeat (4) @(negedge clk);
    below_reset = 1'b0;
    repeat (5) @(negedge clk);
    chk("R13 waits for supply", clr_n, c0);
    chk("R13 still disabled", out_disable, 1);
    below_switch = 1'b0;
    @(negedge clk);
    chk("R13 recall starts", clr_go, 1);
    count_disabled(n);
    chk("R13 power-up length", n, PWR);
  endtask

  task automatic t_inhibit_mode();
    int e0, pulled;
    do_reset(1'b0, 1'b0);
    wait_ready();
    chk("R12 ready", out_disable, 0);
    do_write("R12");
    e0 = erase_n;
    pulled = 0;
    below_switch = 1'b1;
    for (int i = 0; i < ABRT + 6; i++) begin
      @(negedge clk);
      if (busy_pull) pulled = 1;
    end
    chk("R12 no pull", pulled, 0);
    chk("R12 no erase", erase_n, e0);
    chk("R12 writes still blocked", sram_inhibit, 1);
    below_switch = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    do_reset(1'b1, 1'b1);
    t_powerup();
    t_sw_store();
    t_sw_store_hold();
    line_request_ignored("R3");
    t_hw_store();
    t_auto_store();
    t_low_supply_writes();
    t_abort();
    t_sw_recall();
    t_brownout_reset();
    t_inhibit_mode();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule